// File: doc/BRIEF.md
# Interrupt Level Delay Pipe

This block sits between a bank of fourteen interrupt request bits, with their per-source enables and a master enable, and the three-bit priority-level inputs of a CPU. Each cycle it reduces the enabled, pending sources to a single priority level (1 to 6, 0 when nothing is pending). It then passes changes of that level to the CPU side through a fixed-length delay line, measured in colour clocks. This reproduces the few clocks of pipelining that sit between an interrupt controller's encoder and the processor pins.

On the CPU side the block models how a processor observes that level. The level is latched on every bus cycle. At an instruction boundary the take-or-ignore decision uses the value held in that latch, which is the value seen at the instruction's last bus access. A level that arrives during trailing internal cycles is therefore acted on one instruction later. A decision to take an interrupt is reported as a one-cycle pulse with the recognised level, and only when that level is above the CPU's current mask.

Two paths skip the delay. The pending-set readback is always undelayed. The level-2 port source is level-fed, so unmasking it while its request is already latched shows level 2 at once. Any other source exposed by an unmask goes through the delay like a fresh request. With the delay parameter set to 0, the delay line and the bus-cycle latch are both removed: the level is combinational and the boundary decision uses the live level. No port carries a stream. Every input is a plain level or single-cycle strobe with no handshake, so there is no back-pressure.

Top module: `irq_level_pipe`

## Requirements
- R1: Source bits map to levels as follows: bit 13 gives 6; bits 11 and 12 give 5; bits 7 to 10 give 4; bits 4 to 6 give 3; bit 3 (the port source) gives 2; bits 0 to 2 give 1. The output level is the highest level among the enabled pending sources, or 0 when there are none.
- R2: When the master enable is low, no source is pending and the computed level is 0.
- R3: With DELAY > 0, a change of the pending set that is applied before clock edge n reaches `lvl_o` at edge n+DELAY. Before that edge, `lvl_o` holds its earlier value.
- R4: `pend_o` equals `req_i & en_i`, gated by the master enable, in the same cycle with no register.
- R5: With DELAY > 0, when the port source's request was already high in the previous cycle and its effective enable rises, `lvl_o` is at least 2 in that same cycle. It stays at least 2 while that source remains enabled and pending.
- R6: Any other source whose enable rises while its request is held reaches `lvl_o` only after DELAY edges.
- R7: A clock edge with `bus_cyc_i` high latches `lvl_o`. At an edge with `boundary_i` high, the decision uses the latch value from before that edge, so a bus strobe in the same cycle does not count. The result appears on `take_o`/`take_lvl_o` one edge later.
- R8: `take_o` pulses only if the level used for the decision is strictly greater than `mask_i`. `take_lvl_o` then carries that level; otherwise it is 0.
- R9: With DELAY = 0, `lvl_o` follows the pending set combinationally, and the boundary decision uses the live `lvl_o` with no bus cycle needed.
- R10: `lvl_o` never shows level 7.
- R11: During and after reset, `lvl_o`, `take_o` and `take_lvl_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour-clock rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 14 | Latched interrupt request bits |
| en_i | input | 14 | Per-source enable bits |
| master_en_i | input | 1 | Master enable gating every source |
| bus_cyc_i | input | 1 | CPU bus-cycle strobe; latches the level |
| boundary_i | input | 1 | CPU instruction-boundary strobe |
| mask_i | input | 3 | CPU's current interrupt mask level |
| lvl_o | output | 3 | Delayed priority level seen by the CPU |
| pend_o | output | 14 | Undelayed enabled-pending readback |
| take_o | output | 1 | One-cycle take-interrupt pulse |
| take_lvl_o | output | 3 | Level being taken, 0 when no take |

## Verification
The bench sweeps every one of the 16384 request patterns with all sources enabled, and then a masked sweep that also toggles the master enable. In each sweep it checks the delayed level exactly DELAY edges after each pattern, the same-cycle readback, and a zero-delay instance. An off-by-one delay line, or a priority map that lets a lower source win, would miscompare on many vectors. Directed cases cover the unmask paths: a bypass applied to every source would show level 3 early, and a bypass missing for the port source would leave the level at 0 for DELAY clocks. Boundary cases check that a level arriving after the last bus strobe is not taken, and that a level equal to the mask is refused. A design that decided from the live level would take too early, and one that compared with greater-or-equal would take at equality.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;
  localparam int unsigned NUM_SRC  = 14;
  localparam int unsigned LVL_W    = 3;
  localparam int unsigned PORT_BIT = 3;
  localparam int unsigned PORT_LVL = 2;

  typedef logic [LVL_W-1:0]   level_t;
  typedef logic [NUM_SRC-1:0] src_vec_t;

  // Fixed priority of each source bit.
  function automatic level_t level_of_bit(input int unsigned b);
    if (b == 13)            return level_t'(6);
    else if (b >= 11)       return level_t'(5);
    else if (b >= 7)        return level_t'(4);
    else if (b >= 4)        return level_t'(3);
    else if (b == PORT_BIT) return level_t'(PORT_LVL);
    else                    return level_t'(1);
  endfunction
endpackage

// File: rtl/irq_level_encoder.sv
module irq_level_encoder
  import irq_level_pkg::*;
(
  input  src_vec_t pend_i,
  output level_t   lvl_o
);
  always_comb begin
    lvl_o = '0;
    for (int unsigned b = 0; b < NUM_SRC; b++) begin
      if (pend_i[b] && (level_of_bit(b) > lvl_o)) lvl_o = level_of_bit(b);
    end
  end
endmodule

// File: rtl/irq_level_delay_line.sv
module irq_level_delay_line #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned W     = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int unsigned i = 0; i < DEPTH; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int unsigned i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/irq_unmask_bypass.sv
module irq_unmask_bypass (
  input  logic clk,
  input  logic rst_n,
  input  logic req_bit_i,
  input  logic eff_en_i,
  output logic fast_o
);
  logic req_q, en_q, hold_q, fire;

  // Request already latched last cycle, enable just opened.
  assign fire   = req_bit_i & req_q & eff_en_i & ~en_q;
  assign fast_o = fire | hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      en_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      req_q  <= req_bit_i;
      en_q   <= eff_en_i;
      hold_q <= (fire | hold_q) & req_bit_i & eff_en_i;
    end
  end
endmodule

// File: rtl/irq_boundary_sampler.sv
module irq_boundary_sampler
  import irq_level_pkg::*;
#(
  parameter bit LIVE = 1'b0
) (
  input  logic   clk,
  input  logic   rst_n,
  input  level_t lvl_i,
  input  logic   bus_cyc_i,
  input  logic   boundary_i,
  input  level_t mask_i,
  output logic   take_o,
  output level_t take_lvl_o
);
  level_t seen_q, decide;

  generate
    if (LIVE) begin : g_live
      assign decide = lvl_i;
    end else begin : g_latched
      assign decide = seen_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q     <= '0;
      take_o     <= 1'b0;
      take_lvl_o <= '0;
    end else begin
      if (bus_cyc_i) seen_q <= lvl_i;
      take_o     <= boundary_i && (decide > mask_i);
      take_lvl_o <= (boundary_i && (decide > mask_i)) ? decide : '0;
    end
  end
endmodule

// File: rtl/irq_level_pipe.sv
module irq_level_pipe
  import irq_level_pkg::*;
#(
  parameter int unsigned DELAY = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [13:0] req_i,
  input  logic [13:0] en_i,
  input  logic        master_en_i,
  input  logic        bus_cyc_i,
  input  logic        boundary_i,
  input  logic [2:0]  mask_i,
  output logic [2:0]  lvl_o,
  output logic [13:0] pend_o,
  output logic        take_o,
  output logic [2:0]  take_lvl_o
);
  localparam bit LIVE = (DELAY == 0);

  level_t enc_lvl;

  assign pend_o = req_i & en_i & {NUM_SRC{master_en_i}};

  irq_level_encoder u_enc (.pend_i(pend_o), .lvl_o(enc_lvl));

  generate
    if (LIVE) begin : g_nodelay
      assign lvl_o = enc_lvl;
    end else begin : g_delay
      level_t piped;
      logic   fast;

      irq_level_delay_line #(.DEPTH(DELAY), .W(LVL_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .d_i(enc_lvl), .q_o(piped)
      );

      irq_unmask_bypass u_byp (
        .clk(clk), .rst_n(rst_n),
        .req_bit_i(req_i[PORT_BIT]),
        .eff_en_i(en_i[PORT_BIT] & master_en_i),
        .fast_o(fast)
      );

      assign lvl_o = (fast && (piped < level_t'(PORT_LVL))) ? level_t'(PORT_LVL) : piped;
    end
  endgenerate

  irq_boundary_sampler #(.LIVE(LIVE)) u_smp (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_o),
    .bus_cyc_i(bus_cyc_i), .boundary_i(boundary_i), .mask_i(mask_i),
    .take_o(take_o), .take_lvl_o(take_lvl_o)
  );
endmodule

// File: rtl/irq_level_pipe_chk.sv
module irq_level_pipe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [13:0] req_i,
  input logic [13:0] en_i,
  input logic        master_en_i,
  input logic        boundary_i,
  input logic [2:0]  mask_i,
  input logic [2:0]  lvl_o,
  input logic [13:0] pend_o,
  input logic        take_o,
  input logic [2:0]  take_lvl_o
);
  p_level_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_o != 3'd7);

  p_master_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en_i |-> (pend_o == '0));

  p_pend_subset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & ~req_i) == '0) && ((pend_o & ~en_i) == '0));

  p_take_needs_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i));

  p_take_above_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (take_lvl_o > $past(mask_i)));

  p_no_take_no_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (take_lvl_o == 3'd0));

  p_port_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i[3] && $past(req_i[3]) && en_i[3] && master_en_i
     && !$past(en_i[3] && master_en_i)) |-> (lvl_o >= 3'd2));
endmodule

bind irq_level_pipe irq_level_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .en_i(en_i),
  .master_en_i(master_en_i), .boundary_i(boundary_i), .mask_i(mask_i),
  .lvl_o(lvl_o), .pend_o(pend_o), .take_o(take_o), .take_lvl_o(take_lvl_o)
);

// File: tb/irq_level_pipe_test.sv
`timescale 1ns/1ps
module irq_level_pipe_test;
  localparam int DLY = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] req = '0, en = '0;
  logic        master = 1'b0, bus = 1'b0, bnd = 1'b0;
  logic [2:0]  mask = '0;
  logic [2:0]  lvl, lvl0, tlvl, tlvl0;
  logic [13:0] pend, pend0;
  logic        take, take0;
  int nvec = 0, nbad = 0;
  logic [2:0] ring [8];

  always #4 clk = ~clk;

  irq_level_pipe #(.DELAY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .master_en_i(master),
    .bus_cyc_i(bus), .boundary_i(bnd), .mask_i(mask),
    .lvl_o(lvl), .pend_o(pend), .take_o(take), .take_lvl_o(tlvl));

  irq_level_pipe #(.DELAY(0)) uut_nd (
    .clk(clk), .rst_n(rst_n), .req_i(req), .en_i(en), .master_en_i(master),
    .bus_cyc_i(bus), .boundary_i(bnd), .mask_i(mask),
    .lvl_o(lvl0), .pend_o(pend0), .take_o(take0), .take_lvl_o(tlvl0));

  function automatic logic [2:0] exp_lvl(logic [13:0] r, logic [13:0] e, logic m);
    logic [13:0] p = r & e & {14{m}};
    if (p[13])            return 3'd6;
    else if (|p[12:11])   return 3'd5;
    else if (|p[10:7])    return 3'd4;
    else if (|p[6:4])     return 3'd3;
    else if (p[3])        return 3'd2;
    else if (|p[2:0])     return 3'd1;
    return 3'd0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    step(3);
    chk("R11 reset lvl", lvl, 0);
    chk("R11 reset take", take, 0);
    chk("R11 reset take level", tlvl, 0);
    rst_n = 1'b1;
    en = '1; master = 1'b1;
    step(DLY + 2);
    chk("R11 idle lvl after reset", lvl, 0);

    // Sweep 1: all 16384 request patterns, everything enabled (R1 R3 R4 R9 R10).
    for (int i = 0; i < 8; i++) ring[i] = 3'd0;
    for (int k = 0; k < 16384 + DLY; k++) begin
      logic [2:0] e;
      @(negedge clk);
      chk("R3 R1 delayed level", lvl, ring[(k + 8 - DLY) % 8]);
      if (k < 16384) req = 14'(k);
      e = exp_lvl(req, en, master);
      ring[k % 8] = e;
      #1;
      chk("R4 pend readback", pend, req & en);
      chk("R9 R1 zero-delay level", lvl0, e);
      if (lvl == 3'd7) chk("R10 level 7 seen", lvl, 0);
    end

    // Sweep 2: masked, master toggling, port enable held low (R1 R2 R3).
    for (int k = 0; k < 4096 + DLY; k++) begin
      logic [2:0] e;
      @(negedge clk);
      chk("R2 R3 masked delayed level", lvl, ring[(k + 8 - DLY) % 8]);
      if (k < 4096) begin
        req    = 14'(k * 5) ^ 14'h2AAA;
        en     = 14'((k * 3) ^ (k >> 2)) & ~14'h0008;
        master = k[1];
      end
      e = exp_lvl(req, en, master);
      ring[k % 8] = e;
      #1;
      chk("R2 R4 masked pend", pend, req & en & {14{master}});
      if (!master) chk("R2 master off level", lvl0, 0);
    end

    // R5: port source unmasked while already latched.
    @(negedge clk);
    req = 14'h0008; en = '0; master = 1'b1;
    step(DLY + 2);
    chk("R5 port masked", lvl, 0);
    en = 14'h0008;
    #1;
    chk("R5 port unmask immediate", lvl, 2);
    step(1);
    chk("R5 port stays visible", lvl, 2);
    step(DLY);
    chk("R5 port after pipe", lvl, 2);

    // R6: other source unmasked goes through the delay.
    @(negedge clk);
    req = 14'h0020; en = '0;
    step(DLY + 2);
    en = 14'h0020;
    #1;
    chk("R6 no immediate bypass", lvl, 0);
    step(DLY - 1);
    chk("R6 still delayed", lvl, 0);
    step(1);
    chk("R6 arrives after delay", lvl, 3);

    // R7 R8 R9: sampling and decision, level 3 from bit 4.
    @(negedge clk);
    req = '0; en = '1; mask = 3'd0;
    step(DLY + 2);
    req = 14'h0010; bus = 1'b1;      // bus strobe latches level 0
    step(1);
    bus = 1'b0;
    step(DLY + 1);
    chk("R3 level present", lvl, 3);
    bnd = 1'b1;
    step(1);
    bnd = 1'b0;
    chk("R7 level after last bus access not taken", take, 0);
    chk("R9 zero-delay takes live level", take0, 1);
    chk("R9 zero-delay take level", tlvl0, 3);
    bus = 1'b1; bnd = 1'b1;          // same-cycle bus strobe does not count
    step(1);
    bus = 1'b0;
    chk("R7 same-cycle bus ignored", take, 0);
    step(1);
    bnd = 1'b0;
    chk("R7 taken next instruction", take, 1);
    chk("R7 take level", tlvl, 3);
    step(1);
    chk("R7 take is one pulse", take, 0);

    mask = 3'd3; bnd = 1'b1;
    step(1);
    bnd = 1'b0;
    chk("R8 equal to mask refused", take, 0);
    chk("R8 no level when refused", tlvl, 0);
    mask = 3'd2; bnd = 1'b1;
    step(1);
    bnd = 1'b0;
    chk("R8 above mask taken", take, 1);
    chk("R8 taken level", tlvl, 3);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule